// File: doc/BRIEF.md
# Register-Mapped Return-Address Stack

This block is a bounded last-in-first-out store for return addresses. It sits behind one general-purpose register index. An instruction that names that index as a source operand pops the newest entry, and one that names it as the destination pushes a new entry. A single instruction can carry two source operands and one destination, so one cycle may bring two pop requests and one push request together. All eight combinations of these three requests are resolved in that cycle.

The block drives the newest entry on its read-data output for the operand path. It reports its fill level as one of three states: empty, partially full or full. It raises an underflow pulse when a pop finds nothing to remove and an overflow pulse when a push finds no free slot. Register-file storage, decode and any escalation of the error pulses belong to the surrounding core. A synchronous clear empties the stack in one cycle.

Top module: `retaddr_stack`

## Requirements
- R1: After reset the stack is empty: `fill_o` is 2'b00, `topData_o` is zero, and `underflow_o` and `overflow_o` are low.
- R2: A push with no pop on a stack that is not full stores `pushData_i`. From the next cycle that value appears on `topData_o` and the level rises by one.
- R3: A pop alone on a non-empty stack removes the newest entry. Entries leave in the reverse of their push order.
- R4: `fill_o` encodes the level: 2'b00 when no entries are held, 2'b01 for 1 to DEPTH-1 entries, and 2'b10 when DEPTH entries are held.
- R5: A push with no pop on a full stack drives `overflow_o` high in that cycle. It leaves the contents and the level unchanged.
- R6: A pop on an empty stack drives `underflow_o` high in that cycle and leaves the level unchanged. A push in the same cycle is discarded, and `topData_o` stays zero.
- R7: When both pop requests are high in one cycle, exactly one entry is removed. Both operands receive the same top value.
- R8: A pop together with a push on a full stack replaces the newest entry. The stack stays full and `overflow_o` stays low.
- R9: A pop together with a push on a partially full stack replaces the newest entry and leaves the level unchanged.
- R10: `underflow_o` and `overflow_o` are never high in the same cycle.
- R11: `clear_i` empties the stack at the next edge, overrides every request in its cycle, and suppresses both error pulses.
- R12: A cycle with no request and no clear leaves the level and the top value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of the whole stack |
| popA_i | input | 1 | First source operand names the stack register |
| popB_i | input | 1 | Second source operand names the stack register |
| push_i | input | 1 | Destination operand names the stack register |
| pushData_i | input | DATA_W | Value written on a push |
| topData_o | output | DATA_W | Newest entry; zero when the stack is empty |
| fill_o | output | 2 | Fill state: 00 empty, 01 partial, 10 full |
| underflow_o | output | 1 | Pop attempted with no entry held |
| overflow_o | output | 1 | Push attempted with no free slot |

## Verification
A pop and a push can land in the same cycle. The stress points are the two edges: a full stack, where the pair must replace the top without an overflow, and an empty stack, where the pop must underflow and the push must be dropped. The bench drives both combinations at both edges, and at a middle level, with and without the second pop request. Each case is judged by comparing the error pulses in the request cycle, and the top value and fill state after the edge, against a reference stack kept in the bench.

// File: rtl/retaddr_stack_pkg.sv
package retaddr_stack_pkg;

  typedef enum logic [1:0] {
    FILL_EMPTY = 2'b00,
    FILL_PART  = 2'b01,
    FILL_FULL  = 2'b10
  } fill_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;     // write pushData into a slot this cycle
    logic replace;  // write over the newest slot instead of the next free one
  } stackStrobe_t;

endpackage

// File: rtl/retaddr_stack_ctrl.sv
module retaddr_stack_ctrl
  import retaddr_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             popA_i,
  input  logic             popB_i,
  input  logic             push_i,
  output logic [LVL_W-1:0] level_o,
  output stackStrobe_t     strobe_o,
  output fill_e            fill_o,
  output logic             underflow_o,
  output logic             overflow_o
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [LVL_W-1:0] level, levelNext;
  logic popAny, isEmpty, isFull;

  always_comb begin
    popAny      = popA_i | popB_i;   // two pops of the same register count once
    isEmpty     = (level == '0);
    isFull      = (level == FULL_LVL);
    underflow_o = !clear_i && popAny && isEmpty;
    overflow_o  = !clear_i && push_i && !popAny && isFull;
    strobe_o.wrEn    = !clear_i && push_i && !underflow_o && !overflow_o;
    strobe_o.replace = popAny;
    levelNext = level;
    if (clear_i)                                 levelNext = '0;
    else if (popAny && !isEmpty && !push_i)      levelNext = level - 1'b1;
    else if (push_i && !popAny && !isFull)       levelNext = level + 1'b1;
    if (isEmpty)     fill_o = FILL_EMPTY;
    else if (isFull) fill_o = FILL_FULL;
    else             fill_o = FILL_PART;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else        level <= levelNext;
  end

  assign level_o = level;

  // R10: the two error pulses exclude each other
  p_no_both_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(underflow_o && overflow_o));

  // R6: an underflow leaves the level where it was
  p_underflow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> $stable(level));

  // R5: an overflow leaves the level where it was
  p_overflow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> $stable(level));

  // R8 / R9: pop plus push on a non-empty stack keeps the depth
  p_replace_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && popAny && push_i && !isEmpty) |=> $stable(level));

  // R7: a double pop removes exactly one entry
  p_double_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && popA_i && popB_i && !push_i && !isEmpty) |=> (level == $past(level) - 1'b1));

  // R11: clear empties the stack
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (level == '0));

endmodule

// File: rtl/retaddr_stack_dpath.sv
module retaddr_stack_dpath
  import retaddr_stack_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stackStrobe_t      strobe_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [DATA_W-1:0] pushData_i,
  output logic [DATA_W-1:0] topData_o
);

  logic [DATA_W-1:0] slot [DEPTH];
  logic [LVL_W-1:0]  wrIdx;

  assign wrIdx = strobe_i.replace ? (level_i - 1'b1) : level_i;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       slot[g] <= '0;
      else if (strobe_i.wrEn && wrIdx == LVL_W'(g))     slot[g] <= pushData_i;
    end
  end

  // Newest entry sits at level-1; an empty stack reads as zero
  always_comb begin
    topData_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (level_i == LVL_W'(i + 1)) topData_o = slot[i];
  end

  // R5: a write never targets a slot beyond the storage
  p_write_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i.wrEn |-> (wrIdx < LVL_W'(DEPTH)));

endmodule

// File: rtl/retaddr_stack.sv
module retaddr_stack
  import retaddr_stack_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              popA_i,
  input  logic              popB_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] pushData_i,
  output logic [DATA_W-1:0] topData_o,
  output logic [1:0]        fill_o,
  output logic              underflow_o,
  output logic              overflow_o
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [LVL_W-1:0] level;
  stackStrobe_t     strobe;
  fill_e            fillState;

  retaddr_stack_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear_i),
    .popA_i      (popA_i),
    .popB_i      (popB_i),
    .push_i      (push_i),
    .level_o     (level),
    .strobe_o    (strobe),
    .fill_o      (fillState),
    .underflow_o (underflow_o),
    .overflow_o  (overflow_o)
  );

  retaddr_stack_dpath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_i   (strobe),
    .level_i    (level),
    .pushData_i (pushData_i),
    .topData_o  (topData_o)
  );

  assign fill_o = fillState;

  // R4 / R5: an overflow is only possible while the full state is shown
  p_overflow_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> (fill_o == FILL_FULL));

  // R6: an underflow is only possible while the empty state is shown
  p_underflow_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> (fill_o == FILL_EMPTY && topData_o == '0));

endmodule

// File: tb/retaddr_stack_tb.sv
`timescale 1ns/100ps
module retaddr_stack_tb;

  localparam int DEPTH  = 8;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear_i = 1'b0, popA_i = 1'b0, popB_i = 1'b0, push_i = 1'b0;
  logic [DATA_W-1:0] pushData_i = '0;
  logic [DATA_W-1:0] topData_o;
  logic [1:0] fill_o;
  logic underflow_o, overflow_o;

  always #2 clk = ~clk;  // 250 MHz

  retaddr_stack #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .popA_i(popA_i), .popB_i(popB_i),
    .push_i(push_i), .pushData_i(pushData_i), .topData_o(topData_o), .fill_o(fill_o),
    .underflow_o(underflow_o), .overflow_o(overflow_o)
  );

  typedef struct {
    logic              uf;
    logic              of;
    logic [DATA_W-1:0] top;
    logic [1:0]        fill;
    string             tag;
  } exp_t;

  exp_t expQ[$];
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // Reference stack
  logic [DATA_W-1:0] refStk [DEPTH];
  int refCnt = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] refFill();
    if (refCnt == 0)     return 2'b00;
    if (refCnt == DEPTH) return 2'b10;
    return 2'b01;
  endfunction

  // Driver: applies one request cycle and queues the expected outcome
  task automatic step(input bit pa, input bit pb, input bit ps,
                      input logic [DATA_W-1:0] d, input bit clr, input string tag);
    exp_t e;
    bit pop;
    @(posedge clk); #1;
    popA_i = pa; popB_i = pb; push_i = ps; pushData_i = d; clear_i = clr;
    pop = pa | pb;
    e.uf = 1'b0; e.of = 1'b0;
    if (clr) refCnt = 0;
    else if (pop) begin
      if (refCnt == 0) e.uf = 1'b1;
      else if (ps) refStk[refCnt-1] = d;
      else refCnt--;
    end else if (ps) begin
      if (refCnt == DEPTH) e.of = 1'b1;
      else begin refStk[refCnt] = d; refCnt++; end
    end
    e.top  = (refCnt == 0) ? '0 : refStk[refCnt-1];
    e.fill = refFill();
    e.tag  = tag;
    expQ.push_back(e);
  endtask

  // Monitor: errors in the request cycle, state after the edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() != 0) begin
        exp_t e;
        logic uf, of;
        e = expQ[0];
        uf = underflow_o; of = overflow_o;
        check(!(uf && of), "R10", "both errors", {31'b0, uf & of}, '0);
        check(uf == e.uf, e.tag, "underflow", {31'b0, uf}, {31'b0, e.uf});
        check(of == e.of, e.tag, "overflow", {31'b0, of}, {31'b0, e.of});
        @(posedge clk); #0.5;
        check(topData_o == e.top, e.tag, "top", topData_o, e.top);
        check(fill_o == e.fill, e.tag, "fill", {30'b0, fill_o}, {30'b0, e.fill});
        void'(expQ.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(fill_o == 2'b00, "R1", "fill", {30'b0, fill_o}, '0);
    check(topData_o == '0, "R1", "top", topData_o, '0);
    check(!underflow_o && !overflow_o, "R1", "errors", {30'b0, underflow_o, overflow_o}, '0);

    step(0, 0, 1, 32'h1000_00A1, 0, "R2");
    step(0, 0, 1, 32'h1000_00A2, 0, "R2");
    step(0, 0, 1, 32'h1000_00A3, 0, "R4");
    step(1, 0, 0, '0, 0, "R3");
    step(0, 1, 0, '0, 0, "R3");
    step(0, 0, 1, 32'h2000_00B1, 0, "R2");
    step(0, 0, 1, 32'h2000_00B2, 0, "R2");
    step(1, 1, 0, '0, 0, "R7");
    step(1, 0, 1, 32'h3000_00C1, 0, "R9");
    step(1, 1, 1, 32'h3000_00C2, 0, "R9");
    step(0, 0, 0, '0, 0, "R12");
    step(0, 0, 0, '0, 0, "R12");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 32'h4000_0000 + i, 0, "R4");
    step(0, 0, 1, 32'hDEAD_0001, 0, "R5");
    step(0, 0, 1, 32'hDEAD_0002, 0, "R5");
    step(1, 0, 1, 32'h5000_00E1, 0, "R8");
    step(1, 1, 1, 32'h5000_00E2, 0, "R8");
    step(0, 1, 1, 32'h5000_00E3, 0, "R8");
    for (int i = 0; i < DEPTH; i++) step(i % 2, (i + 1) % 2, 0, '0, 0, "R3");
    step(1, 0, 0, '0, 0, "R6");
    step(1, 1, 1, 32'hBAD0_0001, 0, "R6");
    step(0, 1, 1, 32'hBAD0_0002, 0, "R6");
    step(0, 0, 0, '0, 0, "R12");
    step(0, 0, 1, 32'h6000_00F1, 0, "R2");
    step(0, 0, 1, 32'h6000_00F2, 0, "R2");
    step(0, 0, 1, 32'h6000_00F3, 1, "R11");
    step(1, 1, 0, '0, 1, "R11");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 32'h7000_0000 + i, 0, "R4");
    step(0, 0, 1, 32'h7000_00FF, 1, "R11");
    step(0, 0, 1, 32'h8000_0001, 0, "R2");

    @(posedge clk); #1;
    popA_i = 0; popB_i = 0; push_i = 0; clear_i = 0;
    wait (expQ.size() == 0);
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule